// File: doc/BRIEF.md
# Load Issue Disambiguation with Store-Wait Prediction

This block decides, cycle by cycle, whether a load that is ready to go to memory may issue while older stores are still uncommitted. Every memory operation takes a slot in a sixteen-deep ring at dispatch, in program order. A load asks to issue by naming its slot and giving its address. Each older store in the ring is then examined. A store whose address is known and equal to the load's address holds the load back. A store whose address is still unknown holds the load back only if a small prediction table says that this load has caused a conflict before. Otherwise the load goes ahead speculatively.

When a store address arrives later, it is compared with every younger load that has already issued. If one of them used the same address, the block reports a squash for the oldest such load, one cycle later, and sets that load's prediction bit. The actual flush and replay are done elsewhere. That logic gives the surviving tail back to this block with a truncate request. A programmable timer wipes the whole prediction table at a fixed interval, so loads that stopped conflicting can speculate again.

Address comparison is deliberately conservative: only bits [11:0] are compared. A match on those bits counts as a conflict even if the upper bits differ.

Top module: `ld_disambig`

## Requirements
- R1: After reset the ring is empty: `disp_ready` is 1, `disp_tag` is 0 and `squash_valid` is 0. All prediction bits are clear.
- R2: Dispatch writes the slot given by `disp_tag`, and `disp_tag` then advances by one modulo 16. While 16 slots are in use, `disp_ready` is 0 and a dispatch is ignored. `commit_valid` frees the oldest slot.
- R3: A load issues (`ld_issue`=1, `ld_spec`=0) in the cycle of its request when every older store in the ring has a known address whose bits [11:0] differ from the load's bits [11:0].
- R4: An older store whose known address matches the load's address on bits [11:0] holds the load (`ld_issue`=0), even if the upper bits differ. A store address resolved in the same cycle as the request counts as known.
- R5: If an older store address is unknown and the load's prediction bit is clear, the load issues speculatively: `ld_issue`=1 and `ld_spec`=1.
- R6: If an older store address is unknown and the load's prediction bit is set, the load is held until every older store address is known.
- R7: When a store address resolves and matches, on bits [11:0], an already issued load younger than the store, `squash_valid` is 1 in the next cycle with `squash_tag` set to the oldest such load. Loads older than the store, or not yet issued, never cause a squash.
- R8: A squash sets the prediction bit at index `pc[5:0]` of the squashed load (the PC given at its dispatch). Later requests of loads with that index see the bit from the next cycle on.
- R9: With `clr_interval`=N≠0, all prediction bits are cleared every N cycles. 0 disables clearing.
- R10: `trunc_valid` drops slot `trunc_tag` and every younger slot. The next dispatch receives tag `trunc_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch a memory operation |
| disp_store | input | 1 | 1 = store, 0 = load |
| disp_pc | input | 32 | PC of the dispatched operation |
| disp_ready | output | 1 | A free slot exists |
| disp_tag | output | 4 | Slot the next dispatch takes |
| sta_valid | input | 1 | Store address resolves |
| sta_tag | input | 4 | Slot of the resolving store |
| sta_addr | input | 32 | Resolved store address |
| ld_req_valid | input | 1 | A load asks to issue |
| ld_req_tag | input | 4 | Slot of the requesting load |
| ld_req_addr | input | 32 | Address of the requesting load |
| ld_issue | output | 1 | The load may issue this cycle |
| ld_spec | output | 1 | The issue is speculative past an unknown store address |
| commit_valid | input | 1 | Retire the oldest slot |
| trunc_valid | input | 1 | Drop slots from `trunc_tag` to the youngest |
| trunc_tag | input | 4 | First slot dropped |
| clr_interval | input | 16 | Cycles between table wipes, 0 = never |
| squash_valid | output | 1 | A misspeculated load was found |
| squash_tag | output | 4 | Slot of the oldest misspeculated load |

## Verification
The hardest case to reach from the ports is a squash whose pick is ambiguous. This needs several issued loads on both sides of one store, all with the same low address bits, plus an unissued load with the same address. The stimulus sets this up by letting loads speculate past a store whose address is withheld, and only then resolving that store. A second awkward case is a load blocked by a trained prediction bit that becomes free only after the periodic wipe. The bench trains a bit, arms the timer, waits past the interval and repeats the same request. A behavioural reference model tracks the ring, the bits and the timer, and is compared against every output on every cycle.

// File: rtl/ld_disambig_pkg.sv
// Package: shared types of the load disambiguation block.
// Assumes nothing beyond standard SystemVerilog.
package ld_disambig_pkg;

    // Outcome of one load issue request
    typedef enum logic [2:0] {
        DEC_IDLE,       // no request this cycle
        DEC_SAFE,       // all older stores known and different
        DEC_SPEC,       // issues past an unknown store address
        DEC_HOLD_ADDR,  // blocked by a matching known store
        DEC_HOLD_PRED   // blocked by the store-wait prediction
    } ld_dec_e;

endpackage

// File: rtl/oldest_pick.sv
// Module: find-first picker. Returns the lowest set position of req.
// Assumes the caller has rotated req so that bit 0 is the oldest slot.
module oldest_pick #(
    parameter int N = 16,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] pos
);

    // Priority scan: the lowest index wins
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                pos   = W'(i);
            end
        end
    end

endmodule

// File: rtl/swt_clear_timer.sv
// Module: periodic wipe timer for the store-wait table.
// Pulses once every `interval` cycles. An interval of 0 disables it.
// Assumes interval changes are rare. The pulse is reached by >= so that
// shrinking the interval cannot skip it.
module swt_clear_timer #(
    parameter int INTV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INTV_W-1:0] interval,
    output logic              clr_pulse
);

    logic [INTV_W-1:0] cnt;
    logic [INTV_W:0]   cnt_inc;

    // Next count, widened so the compare cannot wrap
    always_comb begin
        cnt_inc   = {1'b0, cnt} + {{INTV_W{1'b0}}, 1'b1};
        clr_pulse = (interval != '0) && (cnt_inc >= {1'b0, interval});
    end

    // Cycle counter, restarts on each pulse or while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (interval == '0 || clr_pulse) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_inc[INTV_W-1:0];
        end
    end

    // R9: with a steady interval above 1, pulses are never back to back
    p_pulse_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && interval > 1 && $stable(interval)) |=> !clr_pulse);

endmodule

// File: rtl/swt_table.sv
// Module: store-wait prediction table, one bit per entry, indexed by load PC bits.
// One read port for the requesting load and one set port from squash detection.
// A set in the same cycle as a wipe survives the wipe.
module swt_table #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             set_valid,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);

    logic [ENTRIES-1:0] bits;

    // Combinational lookup for the requesting load
    assign rd_bit = bits[rd_idx];

    // Wipe first, then the set, so the set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
        end else begin
            if (clr)       bits <= '0;
            if (set_valid) bits[set_idx] <= 1'b1;
        end
    end

    // R8: a trained bit is visible on the next cycle
    p_set_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |=> bits[$past(set_idx)]);

    // R9: a wipe without a concurrent set leaves the table empty
    p_wipe_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_valid) |=> (bits == '0));

endmodule

// File: rtl/ld_disambig.sv
// Module: load issue disambiguation with store-wait prediction.
// Holds in-flight memory operations in a program-ordered ring, decides
// whether a requesting load may issue, detects loads that issued too early
// when a store address resolves, and trains and wipes the prediction table.
// Assumes: QDEPTH is a power of two; requests name live, not yet issued
// load slots; sta_tag names a live store; trunc is not combined with commit.
module ld_disambig #(
    parameter int QDEPTH      = 16,
    parameter int ADDR_W      = 32,
    parameter int PC_W        = 32,
    parameter int CMP_W       = 12,
    parameter int SWT_ENTRIES = 64,
    parameter int INTV_W      = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      disp_valid,
    input  logic                      disp_store,
    input  logic [PC_W-1:0]           disp_pc,
    output logic                      disp_ready,
    output logic [$clog2(QDEPTH)-1:0] disp_tag,
    input  logic                      sta_valid,
    input  logic [$clog2(QDEPTH)-1:0] sta_tag,
    input  logic [ADDR_W-1:0]         sta_addr,
    input  logic                      ld_req_valid,
    input  logic [$clog2(QDEPTH)-1:0] ld_req_tag,
    input  logic [ADDR_W-1:0]         ld_req_addr,
    output logic                      ld_issue,
    output logic                      ld_spec,
    input  logic                      commit_valid,
    input  logic                      trunc_valid,
    input  logic [$clog2(QDEPTH)-1:0] trunc_tag,
    input  logic [INTV_W-1:0]         clr_interval,
    output logic                      squash_valid,
    output logic [$clog2(QDEPTH)-1:0] squash_tag
);
    import ld_disambig_pkg::*;

    localparam int IDX_W     = $clog2(QDEPTH);
    localparam int PTR_W     = IDX_W + 1;
    localparam int SWT_IDX_W = $clog2(SWT_ENTRIES);

    typedef struct packed {
        logic                 is_store;
        logic                 known;
        logic                 issued;
        logic [SWT_IDX_W-1:0] pc_idx;
        logic [CMP_W-1:0]     addr_lo;
    } slot_t;

    slot_t              q [QDEPTH];
    logic [PTR_W-1:0]   head_p, tail_p, count;
    logic [IDX_W-1:0]   head_idx, req_age, sta_age, pick_pos, pick_tag;
    logic [IDX_W-1:0]   ag [QDEPTH];
    logic [QDEPTH-1:0]  live, conflict_v, unknown_v, squash_cand, rot_cand;
    logic               pick_found, req_wait, clr_pulse;
    ld_dec_e            dec;
    logic               unused_bits;

    assign unused_bits = ^{disp_pc[PC_W-1:SWT_IDX_W], sta_addr[ADDR_W-1:CMP_W],
                           ld_req_addr[ADDR_W-1:CMP_W]};

    // Ring occupancy and next dispatch slot
    always_comb begin
        head_idx   = head_p[IDX_W-1:0];
        count      = tail_p - head_p;
        disp_ready = (count != PTR_W'(QDEPTH));
        disp_tag   = tail_p[IDX_W-1:0];
        req_age    = ld_req_tag - head_idx;
        sta_age    = sta_tag - head_idx;
    end

    // Per-slot age, liveness and comparisons against the request and the resolving store
    for (genvar g = 0; g < QDEPTH; g++) begin : g_slot
        logic             sta_here, eff_known, older_st;
        logic [CMP_W-1:0] eff_lo;
        always_comb begin
            ag[g]          = IDX_W'(IDX_W'(g) - head_idx);
            live[g]        = ({1'b0, ag[g]} < count);
            sta_here       = sta_valid && (sta_tag == IDX_W'(g));
            eff_known      = q[g].known || sta_here;
            eff_lo         = sta_here ? sta_addr[CMP_W-1:0] : q[g].addr_lo;
            older_st       = live[g] && q[g].is_store && (ag[g] < req_age);
            conflict_v[g]  = older_st && eff_known && (eff_lo == ld_req_addr[CMP_W-1:0]);
            unknown_v[g]   = older_st && !eff_known;
            squash_cand[g] = sta_valid && live[g] && !q[g].is_store && q[g].issued
                             && (ag[g] > sta_age) && (q[g].addr_lo == sta_addr[CMP_W-1:0]);
        end
    end

    // Issue decision for the requesting load
    always_comb begin
        if (!ld_req_valid)                dec = DEC_IDLE;
        else if (|conflict_v)             dec = DEC_HOLD_ADDR;
        else if (|unknown_v && req_wait)  dec = DEC_HOLD_PRED;
        else if (|unknown_v)              dec = DEC_SPEC;
        else                              dec = DEC_SAFE;
        ld_issue = (dec == DEC_SAFE) || (dec == DEC_SPEC);
        ld_spec  = (dec == DEC_SPEC);
    end

    // Rotate squash candidates so that bit 0 is the oldest slot
    always_comb begin
        for (int k = 0; k < QDEPTH; k++) begin
            rot_cand[k] = squash_cand[IDX_W'(head_idx + IDX_W'(k))];
        end
        pick_tag = head_idx + pick_pos;
    end

    oldest_pick #(.N(QDEPTH), .W(IDX_W)) u_pick (
        .req   (rot_cand),
        .found (pick_found),
        .pos   (pick_pos)
    );

    swt_clear_timer #(.INTV_W(INTV_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .interval  (clr_interval),
        .clr_pulse (clr_pulse)
    );

    swt_table #(.ENTRIES(SWT_ENTRIES), .IDX_W(SWT_IDX_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_pulse),
        .set_valid (pick_found),
        .set_idx   (q[pick_tag].pc_idx),
        .rd_idx    (q[ld_req_tag].pc_idx),
        .rd_bit    (req_wait)
    );

    // Registered squash report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            squash_valid <= 1'b0;
            squash_tag   <= '0;
        end else begin
            squash_valid <= pick_found;
            squash_tag   <= pick_tag;
        end
    end

    // Ring state: resolve, issue record, commit, truncate, dispatch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_p <= '0;
            tail_p <= '0;
            for (int i = 0; i < QDEPTH; i++) q[i] <= '0;
        end else begin
            if (sta_valid) begin
                q[sta_tag].known   <= 1'b1;
                q[sta_tag].addr_lo <= sta_addr[CMP_W-1:0];
            end
            if (ld_issue) begin
                q[ld_req_tag].issued  <= 1'b1;
                q[ld_req_tag].addr_lo <= ld_req_addr[CMP_W-1:0];
            end
            if (commit_valid && count != '0) head_p <= head_p + PTR_W'(1);
            if (trunc_valid) begin
                tail_p <= head_p + PTR_W'(IDX_W'(trunc_tag - head_idx));
            end else if (disp_valid && disp_ready) begin
                q[disp_tag] <= '{is_store: disp_store, known: 1'b0, issued: 1'b0,
                                 pc_idx: disp_pc[SWT_IDX_W-1:0], addr_lo: '0};
                tail_p      <= tail_p + PTR_W'(1);
            end
        end
    end

    // R2: occupancy never exceeds the ring depth
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PTR_W'(QDEPTH));

    // R2: a dispatch into a full ring leaves the tail where it was
    p_full_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_ready && disp_valid && !trunc_valid) |=> $stable(tail_p));

    // R7: a squash is only ever reported after a store resolution
    p_squash_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> $past(sta_valid));

    // R3: an issued load is recorded as issued for later squash checks
    p_issue_recorded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_issue && !trunc_valid) |=> q[$past(ld_req_tag)].issued);

    // R10: truncation puts the next dispatch slot at the truncated tag
    p_trunc_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trunc_valid |=> (disp_tag == $past(trunc_tag)));

endmodule

// File: tb/ld_disambig_tb.sv
// Bench: behavioural reference model of the ring, the table and the timer,
// compared against every output on every cycle.
module ld_disambig_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 0, disp_store = 0;
    logic [31:0] disp_pc = 0;
    logic        disp_ready;
    logic [3:0]  disp_tag;
    logic        sta_valid = 0;
    logic [3:0]  sta_tag = 0;
    logic [31:0] sta_addr = 0;
    logic        ld_req_valid = 0;
    logic [3:0]  ld_req_tag = 0;
    logic [31:0] ld_req_addr = 0;
    logic        ld_issue, ld_spec;
    logic        commit_valid = 0, trunc_valid = 0;
    logic [3:0]  trunc_tag = 0;
    logic [15:0] clr_interval = 0;
    logic        squash_valid;
    logic [3:0]  squash_tag;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ld_disambig u_dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_store(disp_store), .disp_pc(disp_pc),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .sta_valid(sta_valid), .sta_tag(sta_tag), .sta_addr(sta_addr),
        .ld_req_valid(ld_req_valid), .ld_req_tag(ld_req_tag), .ld_req_addr(ld_req_addr),
        .ld_issue(ld_issue), .ld_spec(ld_spec),
        .commit_valid(commit_valid), .trunc_valid(trunc_valid), .trunc_tag(trunc_tag),
        .clr_interval(clr_interval),
        .squash_valid(squash_valid), .squash_tag(squash_tag)
    );

    int    nchk = 0, nerr = 0;
    string cur_req = "R1";

    // Reference model state
    int m_head = 0, m_cnt = 0, m_t = 0, m_sqt = 0;
    bit m_sqv = 0;
    bit m_st[16], m_known[16], m_iss[16];
    int m_pc[16], m_addr[16];
    bit m_sw[64];

    task automatic chk(string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    // One clock: compare outputs, then advance the model on the edge
    task automatic step();
        int ra, sa, j, a, fnd, oh, oc;
        bit blk, unk, kn, e_iss;
        #1;
        ra = (int'(ld_req_tag) - m_head + 16) % 16;
        blk = 0; unk = 0;
        for (int k = 0; k < ra; k++) begin
            j = (m_head + k) % 16;
            if (m_st[j]) begin
                kn = m_known[j] || (sta_valid && int'(sta_tag) == j);
                a  = (sta_valid && int'(sta_tag) == j) ? int'(sta_addr & 32'hfff) : m_addr[j];
                if (kn && a == int'(ld_req_addr & 32'hfff)) blk = 1;
                if (!kn) unk = 1;
            end
        end
        if (unk && m_sw[m_pc[ld_req_tag] % 64]) blk = 1;
        e_iss = ld_req_valid && !blk;
        chk("disp_ready", disp_ready, m_cnt < 16);
        chk("disp_tag", disp_tag, (m_head + m_cnt) % 16);
        chk("ld_issue", ld_issue, e_iss);
        chk("ld_spec", ld_spec, e_iss && unk);
        chk("squash_valid", squash_valid, m_sqv);
        if (m_sqv) chk("squash_tag", squash_tag, m_sqt);
        @(posedge clk);
        oh = m_head; oc = m_cnt;
        fnd = -1;
        if (sta_valid) begin
            sa = (int'(sta_tag) - oh + 16) % 16;
            for (int k = sa + 1; k < oc; k++) begin
                j = (oh + k) % 16;
                if (fnd < 0 && !m_st[j] && m_iss[j] && m_addr[j] == int'(sta_addr & 32'hfff))
                    fnd = j;
            end
        end
        if (clr_interval != 0 && m_t + 1 >= int'(clr_interval)) begin
            for (int i = 0; i < 64; i++) m_sw[i] = 0;
            m_t = 0;
        end else if (clr_interval == 0) m_t = 0;
        else m_t++;
        m_sqv = (fnd >= 0);
        if (fnd >= 0) begin m_sqt = fnd; m_sw[m_pc[fnd] % 64] = 1; end
        if (sta_valid) begin m_known[sta_tag] = 1; m_addr[sta_tag] = int'(sta_addr & 32'hfff); end
        if (e_iss) begin m_iss[ld_req_tag] = 1; m_addr[ld_req_tag] = int'(ld_req_addr & 32'hfff); end
        if (commit_valid && oc > 0) begin m_head = (oh + 1) % 16; m_cnt = oc - 1; end
        if (trunc_valid) m_cnt = (int'(trunc_tag) - oh + 16) % 16;
        else if (disp_valid && oc < 16) begin
            j = (oh + oc) % 16;
            m_st[j] = disp_store; m_known[j] = 0; m_iss[j] = 0;
            m_pc[j] = int'(disp_pc); m_addr[j] = 0;
            m_cnt = m_cnt + 1;
        end
        @(negedge clk);
    endtask

    task automatic do_disp(bit st, int pc, output int tag);
        tag = (m_head + m_cnt) % 16;
        disp_valid = 1; disp_store = st; disp_pc = 32'(pc);
        step();
        disp_valid = 0; disp_store = 0;
    endtask

    task automatic do_req(int tag, int addr);
        ld_req_valid = 1; ld_req_tag = 4'(tag); ld_req_addr = 32'(addr);
        step();
        ld_req_valid = 0;
    endtask

    task automatic do_sta(int tag, int addr);
        sta_valid = 1; sta_tag = 4'(tag); sta_addr = 32'(addr);
        step();
        sta_valid = 0;
    endtask

    task automatic do_trunc(int tag);
        trunc_valid = 1; trunc_tag = 4'(tag);
        step();
        trunc_valid = 0;
    endtask

    task automatic drain();
        while (m_cnt > 0) begin
            commit_valid = 1; step();
        end
        commit_valid = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (20000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int s0, l0, l1, la, lb, lc;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        cur_req = "R1"; idle(2);

        // R3 and R4: known store, conservative low-bit compare
        cur_req = "R2"; do_disp(1, 0, s0); do_disp(0, 5, l0);
        cur_req = "R4"; do_sta(s0, 32'h1234);
        do_req(l0, 32'h5234);            // upper bits differ, low bits match: held
        cur_req = "R3"; do_req(l0, 32'h0300);
        drain();

        // R4: store resolving in the same cycle as the request
        cur_req = "R4"; do_disp(1, 0, s0); do_disp(0, 6, l0);
        sta_valid = 1; sta_tag = 4'(s0); sta_addr = 32'h777;
        do_req(l0, 32'h777); sta_valid = 0;
        cur_req = "R3"; do_req(l0, 32'h778);
        drain();

        // R5, R7, R8, R10, R6: speculate, squash, train, truncate, then wait
        cur_req = "R5"; do_disp(1, 0, s0); do_disp(0, 9, l0);
        do_req(l0, 32'h040);
        cur_req = "R7"; do_sta(s0, 32'h1040);
        idle(1);
        cur_req = "R10"; do_trunc(l0);
        do_disp(1, 0, s0); do_disp(0, 9, l1);
        cur_req = "R6"; do_req(l1, 32'h080);   // trained bit: held
        sta_valid = 1; sta_tag = 4'(s0); sta_addr = 32'h900;
        do_req(l1, 32'h080); sta_valid = 0;    // last store resolves: issues
        drain();

        // R7: oldest of several, older and unissued loads ignored
        cur_req = "R7"; do_disp(0, 3, l0); do_disp(1, 0, s0);
        do_disp(0, 1, la); do_disp(0, 2, lb); do_disp(0, 4, lc);
        do_req(l0, 32'h055); do_req(la, 32'h055); do_req(lb, 32'h055);
        do_sta(s0, 32'h2055);
        idle(1);
        do_trunc(la);
        drain();

        // R8 and R9: trained bit holds the load until the periodic wipe
        cur_req = "R8"; clr_interval = 16'd40;
        do_disp(1, 0, s0); do_disp(0, 1, l0);
        do_req(l0, 32'h010);
        cur_req = "R9"; idle(45);
        do_req(l0, 32'h010);
        do_sta(s0, 32'h999);
        drain();
        clr_interval = 0;

        // R2: full ring ignores a dispatch
        cur_req = "R2";
        for (int i = 0; i < 17; i++) do_disp(0, i, l0);
        idle(1);
        drain();
        idle(2);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule